// File: doc/BRIEF.md
# Level Interrupt Aggregator

This block gathers up to 32 level-type interrupt sources into one request line for a parent controller. Each source that is seen high sets a sticky bit in a status word. A second word holds per-source enables. The request line goes high whenever some bit is set in both words. A dispatcher can read the number of the lowest pending source from a dedicated index output, which comes with a valid flag, so it can service sources in ascending order without scanning the word itself.

Software reaches the two words through a small register bus with an address, a write strobe, write data and combinational read data. Masking and unmasking are read-modify-write updates of the enable word. To acknowledge a source, software writes the status word back with a zero in each position it has serviced and a one in every other position. A write of a one never creates a status bit, because only a source can set one. When a source is still high in the same cycle that its bit is being cleared, the bit stays set, so no event is lost.

Top module: `irqagg_top`

## Requirements
- R1: After reset the status word and the enable word both read as zero, `irq_o` is low and `irq_idx_vld_o` is low.
- R2: A source input that is high at a rising clock edge sets its status bit at that edge, and the bit stays set after the source falls until software clears it.
- R3: A bus write to the status word (offset 0) keeps each status bit whose written bit is 1 and clears each one whose written bit is 0. A written 1 never sets a bit that was clear.
- R4: When a source is high in the same cycle as a status write that clears its bit, the bit is still set after that edge.
- R5: A bus write to the enable word (offset 4) stores the written value unchanged. The value reads back from offset 4 from the next cycle on.
- R6: `irq_o` is high exactly when status AND enable is non-zero.
- R7: When status AND enable is non-zero, `irq_idx_vld_o` is high and `irq_idx_o` gives the bit number of the lowest set bit of status AND enable. When it is zero, `irq_idx_vld_o` is low and `irq_idx_o` is 0.
- R8: With `bus_sel` high, `bus_rdata` gives status at offset 0, enable at offset 4 and zero at any other offset. A write to any other offset changes neither word.
- R9: Writing zero to enable and then zero to status, with all sources low, leaves both words at zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | N_SRC | Level interrupt sources, one bit per source |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Register bus write strobe (valid with bus_sel) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Combinational read data for bus_addr |
| irq_o | output | 1 | Aggregated interrupt request to the parent |
| irq_idx_o | output | $clog2(N_SRC) | Lowest pending source number |
| irq_idx_vld_o | output | 1 | irq_idx_o is meaningful |

## Verification
The bench goes after the acknowledge race, where a source stays high through the clearing write. A design that let the write win would drop the bit and lose an event. It writes all ones to the status word to catch a design that stores the value literally and so invents interrupts, and it writes to an unmapped offset to catch sloppy address decoding that would corrupt enable. It drives sources at bit 0 and bit 31, and sets pending bits together with set bits that are not enabled. An index encoder that picks the highest bit, or that ignores the enable word, then reports the wrong source number.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Byte offsets of the two software-visible words; drivers decode these.
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ENABLE = 4;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_ENABLE = 2'd2
  } rsel_e;

endpackage

// File: rtl/irqagg_rst_sync.sv
module irqagg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output rsel_e             rd_sel,
  output logic              wr_status,
  output logic              wr_enable
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  always_comb begin
    rd_sel = RSEL_NONE;
    if (bus_sel) begin
      if (bus_addr == A_STATUS) begin
        rd_sel = RSEL_STATUS;
      end else if (bus_addr == A_ENABLE) begin
        rd_sel = RSEL_ENABLE;
      end
    end
  end

  always_comb begin
    wr_status = bus_sel && bus_we && (rd_sel == RSEL_STATUS);
    wr_enable = bus_sel && bus_we && (rd_sel == RSEL_ENABLE);
  end

endmodule

// File: rtl/irqagg_stat_cell.sv
module irqagg_stat_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic wr_status,
  input  logic wbit,
  output logic q
);

  logic q_r;
  logic q_d;
  logic ce;

  // A written 0 clears, a written 1 keeps; an active source always sets.
  always_comb begin
    ce  = src | wr_status;
    q_d = ((wr_status ? wbit : 1'b1) & q_r) | src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (ce) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/irqagg_enable_reg.sv
module irqagg_enable_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/irqagg_lowest.sv
module irqagg_lowest #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] pend,
  output logic [IW-1:0]    idx,
  output logic             vld
);

  // Scan from the top so the lowest set bit is the last one to assign.
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
        vld = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic              irq_idx_vld_o
);

  logic             rst_int_n;
  rsel_e            rd_sel;
  logic             wr_status;
  logic             wr_enable;
  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] pend;

  irqagg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irqagg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rd_sel    (rd_sel),
    .wr_status (wr_status),
    .wr_enable (wr_enable)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_stat
    irqagg_stat_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .src       (src_i[g]),
      .wr_status (wr_status),
      .wbit      (bus_wdata[g]),
      .q         (stat_q[g])
    );
  end

  irqagg_enable_reg #(.WIDTH(N_SRC)) u_en (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (wr_enable),
    .wdata (bus_wdata),
    .q     (en_q)
  );

  always_comb begin
    pend  = stat_q & en_q;
    irq_o = |pend;
  end

  irqagg_lowest #(.WIDTH(N_SRC)) u_low (
    .pend (pend),
    .idx  (irq_idx_o),
    .vld  (irq_idx_vld_o)
  );

  always_comb begin
    unique case (rd_sel)
      RSEL_STATUS: bus_rdata = stat_q;
      RSEL_ENABLE: bus_rdata = en_q;
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic [N-1:0]  src_i,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  en_q,
  input logic          irq_o,
  input logic [IW-1:0] irq_idx_o,
  input logic          irq_idx_vld_o
);

  logic armed;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // Covers R2 as well: a sampled source is always reflected next cycle.
  assert_src_wins_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    armed |-> ((stat_q & $past(src_i)) == $past(src_i)));

  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    armed |-> ((stat_q & ~$past(stat_q) & ~$past(src_i)) == '0));

  assert_enable_store_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && bus_we && bus_addr == AW'(4)) |=> (en_q == $past(bus_wdata)));

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && bus_we && bus_addr != AW'(0) && bus_addr != AW'(4))
      |=> ($stable(en_q) && ((stat_q & $past(stat_q)) == $past(stat_q))));

  assert_irq_matches_vld_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == irq_idx_vld_o);

  assert_idx_pending_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_idx_vld_o |-> (stat_q[irq_idx_o] && en_q[irq_idx_o]));

  assert_idx_lowest_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_idx_vld_o |-> ((stat_q & en_q & ((N'(1) << irq_idx_o) - N'(1))) == '0));

endmodule

bind irqagg_top irqagg_chk #(.N(N_SRC), .AW(ADDR_W), .IW(IDX_W)) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .src_i         (src_i),
  .bus_sel       (bus_sel),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .stat_q        (stat_q),
  .en_q          (en_q),
  .irq_o         (irq_o),
  .irq_idx_o     (irq_idx_o),
  .irq_idx_vld_o (irq_idx_vld_o)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int AW = 4;
  localparam int IW = 5;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src_i;
  logic          bus_sel;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic          irq_o;
  logic [IW-1:0] irq_idx_o;
  logic          irq_idx_vld_o;

  irqagg_top #(.N_SRC(N), .ADDR_W(AW)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_i         (src_i),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq_o         (irq_o),
    .irq_idx_o     (irq_idx_o),
    .irq_idx_vld_o (irq_idx_vld_o)
  );

  typedef struct {
    logic [N-1:0]  rd;
    logic          irq;
    logic [IW-1:0] idx;
    logic          vld;
    string         tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [N-1:0] m_stat;
  logic [N-1:0] m_en;
  int           checks;
  int           errors;
  bit           done;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // One clock cycle with the given inputs; the model follows the requirements.
  task automatic drive(input logic [N-1:0] s, input logic sel, input logic we,
                       input logic [AW-1:0] a, input logic [N-1:0] d);
    logic [N-1:0] nxt;
    src_i = s; bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    nxt = m_stat;
    if (sel && we && a == AW'(0)) nxt = nxt & d;   // R3 write clears zeros only
    nxt = nxt | s;                                 // R2 / R4 source wins
    m_stat = nxt;
    if (sel && we && a == AW'(4)) m_en = d;        // R5
    @(negedge clk);
  endtask

  task automatic idle(input logic [N-1:0] s);
    drive(s, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d, input logic [N-1:0] s);
    drive(s, 1'b1, 1'b1, a, d);
  endtask

  // Read at an offset without a clock edge and hand the expectation to the monitor.
  task automatic look(input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic [N-1:0] p;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
    p = m_stat & m_en;
    e.rd  = (a == AW'(0)) ? m_stat : (a == AW'(4)) ? m_en : '0;  // R8
    e.irq = |p;                                                  // R6
    e.vld = |p;                                                  // R7
    e.idx = '0;
    for (int i = N - 1; i >= 0; i--) if (p[i]) e.idx = IW'(i);
    e.tag = tag;
    sb_q.push_back(e);
    #2;
  endtask

  task automatic cmp(input string what, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops each expected item and compares it with the outputs.
  initial begin
    exp_t e;
    forever begin
      wait (sb_q.size() != 0);
      #1;
      e = sb_q.pop_front();
      cmp("rdata", e.tag, bus_rdata, e.rd);
      cmp("irq",   e.tag, N'(irq_o), N'(e.irq));
      cmp("idx",   e.tag, N'(irq_idx_o), N'(e.idx));
      cmp("vld",   e.tag, N'(irq_idx_vld_o), N'(e.vld));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL timeout all-requirements actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    m_stat = '0; m_en = '0;
    rst_n = 1'b0; src_i = '0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle('0);

    // R1 reset state
    look(AW'(0), "R1");
    look(AW'(4), "R1");

    // R2 one-cycle pulse latches and holds; masked so no request (R6)
    idle(N'(1) << 5);
    idle('0);
    idle('0);
    look(AW'(0), "R2");

    // R5 enable store and readback; R6/R7 request and index
    wr(AW'(4), (N'(1) << 5) | (N'(1) << 9), '0);
    look(AW'(4), "R5");
    look(AW'(0), "R6");

    // R7 lower pending but masked bit does not win; then enable it
    idle((N'(1) << 3) | (N'(1) << 9));
    idle('0);
    look(AW'(0), "R7");
    wr(AW'(4), (N'(1) << 3) | (N'(1) << 5) | (N'(1) << 9), '0);
    look(AW'(0), "R7");

    // R3 clear one bit by writing zero there
    wr(AW'(0), ~(N'(1) << 3), '0);
    look(AW'(0), "R3");
    // R3 all-ones write sets nothing new
    wr(AW'(0), '1, '0);
    look(AW'(0), "R3");

    // R4 clearing write loses to an active source in the same cycle
    wr(AW'(0), '0, N'(1) << 5);
    look(AW'(0), "R4");
    // level source held through a clear, then released and cleared
    wr(AW'(0), '0, N'(1) << 5);
    look(AW'(0), "R4");
    idle('0);
    wr(AW'(0), '0, '0);
    look(AW'(0), "R4");

    // R8 unmapped offset: reads zero, write ignored
    wr(AW'(4), N'(32'h0000_ff00), '0);
    idle(N'(1) << 12);
    wr(AW'(8), '1, '0);
    wr(AW'(12), '0, '0);
    look(AW'(8), "R8");
    look(AW'(4), "R8");
    look(AW'(0), "R8");

    // R7 boundaries: bit 31 alone, then bit 0 below it
    wr(AW'(4), '1, '0);
    wr(AW'(0), '0, '0);
    idle(N'(1) << 31);
    idle('0);
    look(AW'(0), "R7");
    idle(N'(1));
    idle('0);
    look(AW'(0), "R7");

    // R9 initialisation sequence
    idle(N'(32'h00f0_0f00));
    idle('0);
    wr(AW'(4), '0, '0);
    wr(AW'(0), '0, '0);
    look(AW'(4), "R9");
    look(AW'(0), "R9");

    // R6 request drops when the enable mask removes the only pending bit
    idle(N'(1) << 17);
    wr(AW'(4), N'(1) << 17, '0);
    look(AW'(0), "R6");
    wr(AW'(4), '0, '0);
    look(AW'(0), "R6");

    idle('0);
    wait (sb_q.size() == 0);
    #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule